// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block converts a stream of phase samples into instantaneous-frequency samples. Each accepted 18-bit phase word is first scaled by a selectable power of two. Only the low 18 bits of the product are kept, so the multiply wraps modulo one full turn. This folds BPSK, QPSK or 8PSK symbol phases onto a single point and strips the data modulation before frequency is measured. The scaled phase is then differenced against a copy taken a programmable number of accepted samples earlier. The 18-bit difference is rounded to a 16-bit frequency word.

A single configuration word sets the multiplier, the enable and the difference span. The same word also carries the settings of the filter that follows the discriminator (tap count, symmetry and decimation). This block decodes those fields and passes them on, but does not act on them.

Top module: `phase_freq_disc`

## Requirements
- R1: `ctrl_word[16:15]` selects the scaling applied before differencing: 0 keeps the phase, 1 doubles it, 2 multiplies it by four and 3 by eight. The product is truncated to 18 bits, so it wraps modulo a full turn.
- R2: When `ctrl_word[14]` is 0, a strobe on `phase_vld` is ignored. No `freq_vld` follows it and the stored history is unchanged. After the block is enabled again, differences are taken against the samples stored before it was disabled.
- R3: `ctrl_word[2:0]` = N sets the span. The difference is taken against the scaled sample accepted N acceptances earlier, and N = 0 behaves as N = 1.
- R4: The difference is formed in 18-bit two's complement. A step that crosses the half-turn point (0x1FFFF to 0x20000) therefore yields a small signed value.
- R5: The 16-bit output is floor((d + 2) / 4), where d is the signed 18-bit difference. A result above 32767 saturates to 0x7FFF. A difference of -131072 gives 0x8000.
- R6: `freq_vld` pulses for one cycle, exactly two clock edges after the edge that accepted the sample. `freq_out` holds its last value in every other cycle.
- R7: `fir_taps` = `ctrl_word[8:3]`, `fir_symmetric` = `ctrl_word[9]`, `fir_even` = `ctrl_word[10]` and `fir_decim` = `ctrl_word[13:11]`. All four follow the control word combinationally.
- R8: During reset, `freq_out` is 0 and `freq_vld` is 0. Every history entry is also cleared to zero phase.
- R9: A cycle without `phase_vld` does not advance the history. Spans are counted in accepted samples, not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phase_in | input | 18 | Phase sample, full turn = 2^18 |
| phase_vld | input | 1 | Sample strobe |
| ctrl_word | input | 17 | Configuration word |
| freq_out | output | 16 | Rounded frequency word |
| freq_vld | output | 1 | Output strobe |
| fir_taps | output | 6 | Decoded filter tap count |
| fir_symmetric | output | 1 | Decoded symmetric/asymmetric select |
| fir_even | output | 1 | Decoded even/odd symmetry select |
| fir_decim | output | 3 | Decoded filter decimation |

## Verification
Two things can happen in the same cycle. The rounding stage can be emitting the result of one sample while the difference stage accepts the next. In that cycle the history is also shifting under the read of the earlier entry. The bench provokes this with back-to-back strobes, strobes separated by gaps, and configuration changes issued on the same edge as a strobe. That includes dropping the enable bit together with a strobe. A behavioural model keeps the history as a queue of integers and applies each configuration at the edge of acceptance. Its expected output is compared on every clock, which shows whether each in-flight result used the settings and history of its own acceptance edge.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int CTRL_W = 17;

  typedef enum logic [1:0] {
    MUL_X1 = 2'b00,
    MUL_X2 = 2'b01,
    MUL_X4 = 2'b10,
    MUL_X8 = 2'b11
  } mul_sel_e;

  // Filter settings forwarded to the next stage
  typedef struct packed {
    logic [2:0] decim;
    logic       even_sym;
    logic       symmetric;
    logic [5:0] taps;
  } fir_cfg_t;

  // Packed so that the field positions match the control word
  typedef struct packed {
    mul_sel_e   mul;
    logic       enable;
    fir_cfg_t   fir;
    logic [2:0] span;
  } disc_cfg_t;
endpackage

// File: rtl/disc_cfg_decode.sv
module disc_cfg_decode
  import disc_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_word,
  output mul_sel_e          mul_sel,
  output logic              enable,
  output logic [2:0]        span,
  output fir_cfg_t          fir_cfg
);
  disc_cfg_t cfg;

  always_comb begin
    cfg     = disc_cfg_t'(ctrl_word);
    mul_sel = cfg.mul;
    enable  = cfg.enable;
    span    = cfg.span;
    fir_cfg = cfg.fir;
  end
endmodule

// File: rtl/disc_phase_scale.sv
module disc_phase_scale
  import disc_pkg::*;
#(
  parameter int PH_W = 18
) (
  input  logic [PH_W-1:0] phase,
  input  mul_sel_e        mul_sel,
  output logic [PH_W-1:0] scaled
);
  // A left shift inside a fixed width is the multiply modulo one turn
  always_comb begin
    case (mul_sel)
      MUL_X1:  scaled = phase;
      MUL_X2:  scaled = phase << 1;
      MUL_X4:  scaled = phase << 2;
      MUL_X8:  scaled = phase << 3;
      default: scaled = phase;
    endcase
  end
endmodule

// File: rtl/disc_history.sv
module disc_history #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     dout
);
  logic [DEPTH-1:0][W-1:0] line_q;
  logic [DEPTH-1:0][W-1:0] line_d;

  assign line_d[0] = shift_en ? din : line_q[0];

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    assign line_d[g] = shift_en ? line_q[g-1] : line_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign dout = line_q[rd_idx];

  // R2 R9
  history_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(line_q));
endmodule

// File: rtl/disc_round_sat.sv
module disc_round_sat #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16,
  localparam int SH   = IN_W - OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  diff,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_word
);
  localparam logic [IN_W:0] RND = (IN_W+1)'(1) << (SH - 1);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  logic [IN_W:0]    sum;
  logic [OUT_W:0]   quot;
  logic             pos_ovf;
  logic [OUT_W-1:0] rounded;
  logic             vld_d;
  logic [OUT_W-1:0] word_d;

  always_comb begin
    sum     = {diff[IN_W-1], diff} + RND;
    quot    = sum[IN_W:SH];
    pos_ovf = !quot[OUT_W] && quot[OUT_W-1];
    rounded = pos_ovf ? POS_MAX : quot[OUT_W-1:0];
    vld_d   = in_vld;
    word_d  = in_vld ? rounded : out_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld  <= vld_d;
      out_word <= word_d;
    end
  end

  // R5
  no_pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !diff[IN_W-1]) |=> !out_word[OUT_W-1]);
endmodule

// File: rtl/phase_freq_disc.sv
module phase_freq_disc
  import disc_pkg::*;
#(
  parameter int PH_W       = 18,
  parameter int OUT_W      = 16,
  parameter int HIST_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase_in,
  input  logic              phase_vld,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic [OUT_W-1:0]  freq_out,
  output logic              freq_vld,
  output logic [5:0]        fir_taps,
  output logic              fir_symmetric,
  output logic              fir_even,
  output logic [2:0]        fir_decim
);
  localparam int IDX_W = $clog2(HIST_DEPTH);

  mul_sel_e         mul_sel;
  logic             enable;
  logic [2:0]       span;
  fir_cfg_t         fir_cfg;
  logic [PH_W-1:0]  scaled;
  logic [PH_W-1:0]  prev;
  logic [IDX_W-1:0] rd_idx;
  logic             accept;
  logic [PH_W-1:0]  diff_d, diff_q;
  logic             s1_vld_d, s1_vld_q;

  disc_cfg_decode u_dec (
    .ctrl_word (ctrl_word),
    .mul_sel   (mul_sel),
    .enable    (enable),
    .span      (span),
    .fir_cfg   (fir_cfg)
  );

  assign fir_taps      = fir_cfg.taps;
  assign fir_symmetric = fir_cfg.symmetric;
  assign fir_even      = fir_cfg.even_sym;
  assign fir_decim     = fir_cfg.decim;

  disc_phase_scale #(.PH_W(PH_W)) u_scale (
    .phase   (phase_in),
    .mul_sel (mul_sel),
    .scaled  (scaled)
  );

  assign accept = phase_vld && enable;
  assign rd_idx = (span == 3'd0) ? '0 : IDX_W'(span - 3'd1);

  disc_history #(.W(PH_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (scaled),
    .rd_idx   (rd_idx),
    .dout     (prev)
  );

  always_comb begin
    s1_vld_d = accept;
    diff_d   = accept ? (scaled - prev) : diff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      diff_q   <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      diff_q   <= diff_d;
    end
  end

  disc_round_sat #(.IN_W(PH_W), .OUT_W(OUT_W)) u_round (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (s1_vld_q),
    .diff     (diff_q),
    .out_vld  (freq_vld),
    .out_word (freq_out)
  );

  // R1
  always_comb begin
    scale_low_bits_chk: assert ((scaled & PH_W'((1 << mul_sel) - 1)) == '0);
  end

  // R6
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_vld |-> $past(accept, 2));

  // R6
  stage_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |=> freq_vld);
endmodule

// File: tb/tb_phase_freq_disc.sv
module tb_phase_freq_disc;
  logic        clk;
  logic        rst_n;
  logic [17:0] phase_in;
  logic        phase_vld;
  logic [16:0] ctrl_word;
  logic [15:0] freq_out;
  logic        freq_vld;
  logic [5:0]  fir_taps;
  logic        fir_symmetric;
  logic        fir_even;
  logic [2:0]  fir_decim;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  phase_freq_disc dut (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .phase_vld(phase_vld),
    .ctrl_word(ctrl_word), .freq_out(freq_out), .freq_vld(freq_vld),
    .fir_taps(fir_taps), .fir_symmetric(fir_symmetric), .fir_even(fir_even),
    .fir_decim(fir_decim)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // Behavioural reference model
  int          hist[$];
  bit          m_vld1, m_vld2;
  logic [15:0] m_val1, m_out;

  function automatic logic [15:0] model_word(int d);
    int q;
    q = (d + 2) >>> 2;
    if (q > 32767) q = 32767;
    return q[15:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < 8; i++) hist.push_back(0);
      m_vld1 = 0; m_vld2 = 0; m_val1 = '0; m_out = '0;
    end else begin
      m_vld2 = m_vld1;
      if (m_vld1) m_out = m_val1;
      if (phase_vld && ctrl_word[14]) begin
        int k, sc, n, d;
        k  = int'(ctrl_word[16:15]);
        sc = (int'(phase_in) << k) & 32'h3FFFF;
        n  = (ctrl_word[2:0] == 0) ? 1 : int'(ctrl_word[2:0]);
        d  = (sc - hist[n-1]) & 32'h3FFFF;
        if (d >= 131072) d = d - 262144;
        m_val1 = model_word(d);
        m_vld1 = 1;
        hist.push_front(sc);
        void'(hist.pop_back());
      end else begin
        m_vld1 = 0;
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (freq_vld !== m_vld2) begin
        errors++;
        $display("FAIL R6/R2/R8 strobe: got %0b exp %0b", freq_vld, m_vld2);
      end
      checks++;
      if (freq_out !== m_out) begin
        errors++;
        $display("FAIL R1/R3/R4/R5/R9 data: got %h exp %h", freq_out, m_out);
      end
      checks++;
      if ({fir_decim, fir_even, fir_symmetric, fir_taps} !==
          {ctrl_word[13:11], ctrl_word[10], ctrl_word[9], ctrl_word[8:3]}) begin
        errors++;
        $display("FAIL R7 fields: got %h exp %h",
                 {fir_decim, fir_even, fir_symmetric, fir_taps}, ctrl_word[13:3]);
      end
    end
  end

  task automatic drive(input logic [17:0] ph, input logic v);
    @(negedge clk);
    phase_in  = ph;
    phase_vld = v;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [16:0] mk(int mul, bit en, int span);
    return {2'(mul), en, 11'd0, 3'(span)};
  endfunction

  initial begin
    rst_n = 0; phase_in = '0; phase_vld = 0; ctrl_word = mk(0, 1, 1);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset out", freq_out, 16'h0000);
    chk("R8 reset vld", {15'd0, freq_vld}, 16'h0000);
    rst_n = 1;

    // R5 positive saturation against cleared history
    drive(18'h1FFFF, 1); drive('0, 0); @(negedge clk);
    chk("R5 saturate", freq_out, 16'h7FFF);
    chk("R6 strobe", {15'd0, freq_vld}, 16'h0001);
    // R5 most negative difference
    drive(18'h20000, 1); drive(18'h00000, 1); drive('0, 0); @(negedge clk);
    chk("R5 negative limit", freq_out, 16'h8000);
    // R4 step across the half-turn point
    drive(18'h1FFF0, 1); drive(18'h20010, 1); drive('0, 0); @(negedge clk);
    chk("R4 wrap", freq_out, 16'h0008);

    // R3 every span, including 0, with a ramp
    for (int s = 0; s < 8; s++) begin
      ctrl_word = mk(0, 1, s);
      for (int i = 0; i < 10; i++) drive(18'(i * 1234 + s * 77), 1);
    end
    // R1 each multiplier
    for (int m = 0; m < 4; m++) begin
      ctrl_word = mk(m, 1, 2);
      for (int i = 0; i < 12; i++) drive(18'(i * 9000 + 40000), 1);
    end
    // R2 disabled strobes, enable dropped on a strobe edge
    ctrl_word = mk(0, 1, 1);
    drive(18'h01000, 1);
    @(negedge clk); ctrl_word = mk(0, 0, 1); phase_in = 18'h3F000;
    for (int i = 0; i < 5; i++) drive(18'(i * 50000), 1);
    drive('0, 0); @(negedge clk);
    chk("R2 no strobe", {15'd0, freq_vld}, 16'h0000);
    ctrl_word = mk(0, 1, 1);
    drive(18'h01100, 1); drive('0, 0); @(negedge clk);
    chk("R2 history kept", freq_out, 16'h0040);
    // R9 gaps between strobes
    ctrl_word = mk(1, 1, 3);
    for (int i = 0; i < 30; i++) drive(18'(i * 3001), (i % 3) != 1);
    // R7 field sweep
    for (int f = 0; f < 64; f++) begin
      @(negedge clk); ctrl_word = {2'd0, 1'b0, 11'(f * 37), 3'd1}; phase_vld = 0;
    end
    // Mixed traffic with changing configuration
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      phase_in  = 18'($urandom);
      phase_vld = ($urandom % 4) != 0;
      if ((i % 7) == 0) ctrl_word = 17'($urandom) | 17'h04000;
      if ((i % 29) == 0) ctrl_word[14] = 1'b0;
    end
    drive('0, 0); repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule